// File: doc/BRIEF.md
# Two-Phase Master-Slave Word Register

This block holds one data word in two explicit stages. The first stage is the master, the second is the slave, and two phase strobes called tick and tock move data between them. A tick captures the input word into the master when the load enable is high. A tock then copies the master into the slave. Only the slave drives the architectural output, so a new word becomes visible there only after the complete tick/tock pair.

Both strobes are single-cycle pulses sampled on one fast system clock. The master contents are also driven onto a separate debug tap. Between a tick and the following tock, the tap shows the word that is pending, while the output still shows the previous word. If tick and tock are asserted in the same clock cycle, the block holds both stages and raises an error flag.

Top module: `two_phase_reg`

## Requirements
- R1: A synchronous active-high reset sets the master, the slave and the error flag to zero. After reset both `q` and `master_tap` read 0.
- R2: On a clock edge where tick is 1, tock is 0 and load is 1, the master takes `din`. `master_tap` shows the new value from that edge on.
- R3: A tick edge leaves `q` unchanged, and `q` keeps the previous slave value.
- R4: On a clock edge where tock is 1 and tick is 0, the slave copies the master. `q` then equals the master value and `master_tap` is unchanged.
- R5: On edges with neither strobe, both stages hold, whatever `din` and `load` do. This also covers input changes between a tick and its tock, so that tock transfers the word captured at the tick.
- R6: On a tick edge with load at 0, the master keeps its value. A following tock then writes that same retained value to `q`.
- R7: A second tick before a tock overwrites the master under the same load rule. `q` changes only at the tock, and takes the latest captured word.
- R8: If tick and tock are both 1 in the same cycle, both stages hold. `clash_err` is 1 in the cycle after that edge and 0 after any edge without a clash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which the strobes are sampled |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | First-phase strobe; master capture |
| tock | input | 1 | Second-phase strobe; slave transfer |
| load | input | 1 | Capture enable used at tick |
| din | input | 16 | Data word to store |
| q | output | 16 | Slave stage, the architectural output |
| master_tap | output | 16 | Debug view of the master stage |
| clash_err | output | 1 | Set for one cycle after a tick and tock collision |

## Verification
The hold and transfer properties assume that tick and tock are single-cycle pulses sampled on the rising edge. They also assume that a collision of the two strobes is the only illegal combination and that it is handled by holding state. The stimulus drives every input at the falling edge, so each rising edge sees stable values. Directed sequences change `din` and `load` on idle cycles between a tick and its tock, and issue double ticks, ticks with load low, and deliberate strobe collisions. A long run of mixed strobe patterns then compares the behavioural model against the design on every cycle.

// File: rtl/msreg_pkg.sv
`timescale 1ns/1ps
package msreg_pkg;

    localparam int unsigned DEFAULT_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TICK  = 2'd1,
        PH_TOCK  = 2'd2,
        PH_CLASH = 2'd3
    } phase_e;

    function automatic phase_e classify(input logic tk, input logic tc);
        phase_e p;
        unique case ({tc, tk})
            2'b01:   p = PH_TICK;
            2'b10:   p = PH_TOCK;
            2'b11:   p = PH_CLASH;
            default: p = PH_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/msreg_phase.sv
`timescale 1ns/1ps
module msreg_phase
    import msreg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   tock,
    output phase_e phase,
    output logic   clash_err
);

    always_comb begin
        phase = classify(tick, tock);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clash_err <= 1'b0;
        end else begin
            clash_err <= (phase == PH_CLASH);
        end
    end

    assert_clash_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && tock) |=> clash_err);
    assert_clash_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !(tick && tock) |=> !clash_err);

endmodule

// File: rtl/msreg_master.sv
`timescale 1ns/1ps
module msreg_master
    import msreg_pkg::*;
#(
    parameter int unsigned W = DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  phase_e       phase,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] held
);

    logic capture;

    always_comb begin
        capture = (phase == PH_TICK) && load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (capture) begin
            held <= din;
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TICK && load) |=> held == $past(din));
    assert_noload_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TICK && !load) |=> $stable(held));
    assert_master_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_TOCK) |=> $stable(held));

endmodule

// File: rtl/msreg_slave.sv
`timescale 1ns/1ps
module msreg_slave
    import msreg_pkg::*;
#(
    parameter int unsigned W = DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  phase_e       phase,
    input  logic [W-1:0] from_master,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (phase == PH_TOCK) begin
            value <= from_master;
        end
    end

    assert_tock_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TOCK) |=> value == $past(from_master));
    assert_tick_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TICK) |=> $stable(value));
    assert_slave_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> $stable(value));

endmodule

// File: rtl/two_phase_reg.sv
`timescale 1ns/1ps
module two_phase_reg
    import msreg_pkg::*;
#(
    parameter int unsigned W = DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         tock,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] master_tap,
    output logic         clash_err
);

    phase_e         phase;
    logic [W-1:0]   mstr;
    logic [W-1:0]   slv;

    msreg_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .tock      (tock),
        .phase     (phase),
        .clash_err (clash_err)
    );

    msreg_master #(.W(W)) u_master (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .load  (load),
        .din   (din),
        .held  (mstr)
    );

    msreg_slave #(.W(W)) u_slave (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .from_master (mstr),
        .value       (slv)
    );

    assign q          = slv;
    assign master_tap = mstr;

    assert_clash_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && tock) |=> ($stable(q) && $stable(master_tap)));
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (q == '0 && master_tap == '0 && !clash_err));

endmodule

// File: tb/two_phase_reg_bench.sv
`timescale 1ns/1ps
module two_phase_reg_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         tock = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic [W-1:0] master_tap;
    logic         clash_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_ref = '0;
    logic [W-1:0] s_ref = '0;
    logic         e_ref = 1'b0;

    always #2.5 clk = ~clk;

    two_phase_reg #(.W(W)) u_two_phase_reg (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .tock       (tock),
        .load       (load),
        .din        (din),
        .q          (q),
        .master_tap (master_tap),
        .clash_err  (clash_err)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                         input string what, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic tk, input logic tc,
                        input logic ld, input logic [W-1:0] d, input string req);
        @(negedge clk);
        rst = r; tick = tk; tock = tc; load = ld; din = d;
        @(posedge clk);
        if (r) begin
            m_ref = '0; s_ref = '0; e_ref = 1'b0;
        end else begin
            e_ref = tk && tc;
            if (tk && !tc && ld) m_ref = d;
            if (tc && !tk) s_ref = m_ref;
        end
        #1;
        check(q, s_ref, "q", req);
        check(master_tap, m_ref, "master_tap", req);
        check({{(W-1){1'b0}}, clash_err}, {{(W-1){1'b0}}, e_ref}, "clash_err", req);
    endtask

    initial begin
        step(1, 0, 0, 0, 16'h0000, "R1");
        step(1, 1, 0, 1, 16'hFFFF, "R1");
        step(0, 0, 0, 0, 16'h0000, "R1");
        // capture at tick, output still old
        step(0, 1, 0, 1, 16'h1111, "R2");
        // inputs wander between tick and tock
        step(0, 0, 0, 1, 16'hAAAA, "R5");
        step(0, 0, 0, 0, 16'h5555, "R5");
        step(0, 0, 1, 1, 16'h0000, "R4");
        step(0, 0, 0, 1, 16'h7777, "R5");
        // tick with load low
        step(0, 1, 0, 0, 16'h2222, "R6");
        step(0, 0, 1, 0, 16'h2222, "R6");
        // double tick
        step(0, 1, 0, 1, 16'h3333, "R7");
        step(0, 1, 0, 1, 16'h4444, "R7");
        step(0, 0, 1, 0, 16'h0000, "R7");
        step(0, 1, 0, 1, 16'h6666, "R7");
        step(0, 1, 0, 0, 16'h9999, "R7");
        step(0, 0, 1, 0, 16'h0000, "R7");
        // collision
        step(0, 1, 1, 1, 16'h5A5A, "R8");
        step(0, 0, 0, 0, 16'h0000, "R8");
        step(0, 1, 0, 1, 16'hBEEF, "R3");
        step(0, 1, 1, 1, 16'hC0DE, "R8");
        step(0, 1, 1, 0, 16'hC0DE, "R8");
        step(0, 0, 1, 0, 16'h0000, "R4");
        // mid-state reset
        step(0, 1, 0, 1, 16'h1234, "R2");
        step(1, 0, 0, 0, 16'h0000, "R1");
        step(0, 0, 0, 0, 16'h0000, "R1");
        for (int i = 0; i < 400; i++) begin
            int unsigned k;
            logic [W-1:0] d;
            k = $urandom % 8;
            d = W'($urandom);
            if (k < 3)      step(0, 1, 0, k[0], d, "R2");
            else if (k < 6) step(0, 0, 1, k[0], d, "R4");
            else if (k == 6) step(0, 0, 0, 1, d, "R5");
            else            step(0, 1, 1, 1, d, "R8");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100us;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule